// File: doc/BRIEF.md
# Function-Coded Integer ALU

This block is a purely combinational arithmetic and logic unit for a simple datapath. Two operands of a configurable width enter together with a three-bit function code. The unit returns one result word and a flag that is high whenever that word is entirely zero. A branch-compare stage can use the flag directly after a subtraction.

A single carry-propagate adder does addition, subtraction and signed compare. The top bit of the function code decides whether the second operand is complemented before it reaches the adder and the logic gates, and the same bit is the adder's carry-in. The low two bits then pick which of four internal results reaches the output: the bitwise AND, the bitwise OR, the adder sum, or the sum's sign bit widened with zeros. Because of this, the code also provides AND-with-complement and OR-with-complement at no extra cost. One code (low bits 11, top bit 0) is reserved and yields zero.

Top module: `fc_alu`

## Requirements
- R1: Code 000 gives result = opnd_a AND opnd_b, bit by bit.
- R2: Code 001 gives result = opnd_a OR opnd_b, bit by bit.
- R3: Code 010 gives result = (opnd_a + opnd_b) modulo 2^WIDTH; carry out is discarded.
- R4: Code 110 gives result = (opnd_a - opnd_b) modulo 2^WIDTH, formed as opnd_a + NOT opnd_b + 1.
- R5: Code 100 gives result = opnd_a AND NOT opnd_b.
- R6: Code 101 gives result = opnd_a OR NOT opnd_b.
- R7: Code 111 gives result with bit 0 equal to bit WIDTH-1 of (opnd_a - opnd_b) and all other bits zero; signed overflow is not corrected (most negative minus 1 yields 0).
- R8: The reserved code 011 drives the result to all zeros, whatever the operands.
- R9: is_zero is 1 exactly when every bit of result is 0, for every code including 011.
- R10: The block holds no state: result and is_zero follow the present inputs within the same clock cycle, and the past inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, complemented when func[2] is 1 |
| func | input | 3 | Function code: bit 2 invert/carry-in, bits 1:0 output select |
| result | output | WIDTH | Selected result word |
| is_zero | output | 1 | High when result is all zeros |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench applies operands and code just after a rising edge and reads result and is_zero at the following falling edge, half a period later, when the inputs have settled. Operand sets are chosen so that a result left over from the previous vector would differ from the expected value, which shows that R10 holds. The corner operands are zero, all ones, the most negative value and equal pairs. They cover carry wrap, borrow and the overflowing compare.

// File: rtl/fc_alu_pkg.sv
package fc_alu_pkg;

   // Output selection carried by the low two bits of the function code.
   typedef enum logic [1:0] {
      OSEL_AND  = 2'b00,
      OSEL_OR   = 2'b01,
      OSEL_SUM  = 2'b10,
      OSEL_SIGN = 2'b11
   } osel_e;

   typedef struct packed {
      logic  invert_b;
      osel_e osel;
   } fcode_t;

   localparam int unsigned FCODE_W = 3;

   function automatic fcode_t split_code(input logic [FCODE_W-1:0] code);
      fcode_t c;
      c.invert_b = code[2];
      c.osel     = osel_e'(code[1:0]);
      return c;
   endfunction

endpackage

// File: rtl/fc_alu_operand.sv
module fc_alu_operand #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] raw_b,
   input  logic             invert,
   output logic [WIDTH-1:0] eff_b
);
   always_comb begin
      eff_b = invert ? ~raw_b : raw_b;
   end
endmodule

// File: rtl/fc_alu_adder.sv
module fc_alu_adder #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          USE_RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum
);
   generate
      if (USE_RIPPLE) begin : g_ripple
         always_comb begin
            logic c;
            c = cin;
            for (int i = 0; i < WIDTH; i++) begin
               sum[i] = x[i] ^ y[i] ^ c;
               c      = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
            end
         end
      end else begin : g_native
         logic [WIDTH:0] full;
         always_comb begin
            full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
            sum  = full[WIDTH-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/fc_alu_logic.sv
module fc_alu_logic #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] and_w,
   output logic [WIDTH-1:0] or_w
);
   always_comb begin
      and_w = x & y;
      or_w  = x | y;
   end
endmodule

// File: rtl/fc_alu_zero.sv
module fc_alu_zero #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned GROUP = 8
) (
   input  logic [WIDTH-1:0] word,
   output logic             all_zero
);
   localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;
   localparam int unsigned PADW = NGRP * GROUP;

   logic [PADW-1:0] padded;
   logic [NGRP-1:0] grp_any;

   always_comb begin
      padded = '0;
      padded[WIDTH-1:0] = word;
   end

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         assign grp_any[g] = |padded[g*GROUP +: GROUP];
      end
   endgenerate

   assign all_zero = ~|grp_any;
endmodule

// File: rtl/fc_alu.sv
module fc_alu #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          USE_RIPPLE = 1'b0,
   parameter int unsigned ZGROUP     = 8
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [2:0]       func,
   output logic [WIDTH-1:0] result,
   output logic             is_zero
);
   import fc_alu_pkg::*;

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fc_alu: WIDTH must be at least 2");
      end
      if (ZGROUP < 1) begin : g_bad_group
         $error("fc_alu: ZGROUP must be at least 1");
      end
   endgenerate

   fcode_t          code;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum_w;
   logic [WIDTH-1:0] and_w;
   logic [WIDTH-1:0] or_w;
   logic [WIDTH-1:0] sign_w;

   assign code = split_code(func);

   fc_alu_operand #(.WIDTH(WIDTH)) u_operand (
      .raw_b  (opnd_b),
      .invert (code.invert_b),
      .eff_b  (b_eff)
   );

   fc_alu_adder #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) u_adder (
      .x   (opnd_a),
      .y   (b_eff),
      .cin (code.invert_b),
      .sum (sum_w)
   );

   fc_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .x     (opnd_a),
      .y     (b_eff),
      .and_w (and_w),
      .or_w  (or_w)
   );

   // Sign of the sum, zero-extended; the reserved code (select 11 without
   // inversion) is forced to zero here.
   always_comb begin
      sign_w    = '0;
      sign_w[0] = sum_w[MSB] & code.invert_b;
   end

   always_comb begin
      unique case (code.osel)
         OSEL_AND:  result = and_w;
         OSEL_OR:   result = or_w;
         OSEL_SUM:  result = sum_w;
         OSEL_SIGN: result = sign_w;
         default:   result = '0;
      endcase
   end

   fc_alu_zero #(.WIDTH(WIDTH), .GROUP(ZGROUP)) u_zero (
      .word     (result),
      .all_zero (is_zero)
   );
endmodule

// File: rtl/fc_alu_checker.sv
module fc_alu_checker #(
   parameter int unsigned WIDTH = 32
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [2:0]       func,
   input logic [WIDTH-1:0] result,
   input logic             is_zero
);
   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, func})) begin
         if (func == 3'b000) a_r1_and_word: assert (result == (opnd_a & opnd_b));
         if (func == 3'b001) a_r2_or_word: assert (result == (opnd_a | opnd_b));
         if (func == 3'b010) a_r3_sum_wraps: assert (result == WIDTH'(opnd_a + opnd_b));
         if (func == 3'b110) a_r4_difference: assert (result == WIDTH'(opnd_a - opnd_b));
         if (func == 3'b100) a_r5_and_not: assert (result == (opnd_a & ~opnd_b));
         if (func == 3'b101) a_r6_or_not: assert (result == (opnd_a | ~opnd_b));
         if (func == 3'b111) a_r7_slt_one_bit: assert ((result >> 1) == '0);
         if (func == 3'b011) a_r8_reserved_zero: assert (result == '0);
         a_r9_zero_flag: assert (is_zero == (result == '0));
      end
   end
endmodule

bind fc_alu fc_alu_checker #(.WIDTH(WIDTH)) u_fc_alu_checker (
   .opnd_a  (opnd_a),
   .opnd_b  (opnd_b),
   .func    (func),
   .result  (result),
   .is_zero (is_zero)
);

// File: tb/fc_alu_bench.sv
module fc_alu_bench;
   localparam int unsigned W = 32;
   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic [2:0]   f;
   logic [W-1:0] y;
   logic         z;
   int           n_chk = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fc_alu #(.WIDTH(W)) u_fc_alu (
      .opnd_a(a), .opnd_b(b), .func(f), .result(y), .is_zero(z)
   );

   // Expected value built from the requirement text.
   function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] v,
                                          input logic [2:0] c);
      logic [W-1:0] d;
      d = x - v;
      case (c)
         3'b000: return x & v;
         3'b001: return x | v;
         3'b010: return x + v;
         3'b100: return x & ~v;
         3'b101: return x | ~v;
         3'b110: return d;
         3'b111: return {{(W-1){1'b0}}, d[W-1]};
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] c);
      case (c)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b110: return "R4";
         3'b100: return "R5";
         3'b101: return "R6";
         3'b111: return "R7";
         default: return "R8";
      endcase
   endfunction

   // Apply after a rising edge, sample at the falling edge (same cycle).
   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] v, input logic [2:0] c);
      @(posedge clk);
      a = x; b = v; f = c;
      @(negedge clk);
   endtask

   task automatic check_now(input string req, input logic [W-1:0] exp_y);
      n_chk++;
      if (y !== exp_y) begin
         n_fail++;
         $display("FAIL %s code=%b a=%h b=%h: result actual %h expected %h", req, f, a, b, y, exp_y);
      end
      n_chk++;
      if (z !== (exp_y == '0)) begin
         n_fail++;
         $display("FAIL R9 code=%b: is_zero actual %b expected %b", f, z, (exp_y == '0));
      end
   endtask

   task automatic run_vec(input logic [W-1:0] x, input logic [W-1:0] v, input logic [2:0] c);
      apply(x, v, c);
      check_now(req_of(c), model(x, v, c));
   endtask

   task automatic t_start_state;
      apply('0, '0, 3'b000);
      check_now("R1", '0);   // all-zero inputs give zero result, flag high
   endtask

   task automatic t_logic_ops;
      for (int c = 0; c < 8; c++) begin
         if (c == 2 || c == 3 || c >= 6) continue;
         run_vec(32'hF0F0_A5A5, 32'h0FF0_5AA5, 3'(c));
         run_vec(ONES, '0, 3'(c));
         run_vec('0, ONES, 3'(c));
      end
   endtask

   task automatic t_arith;
      run_vec(ONES, 32'd1, 3'b010);        // R3 wrap to zero
      run_vec(MNEG, MNEG, 3'b010);         // R3 carry out lost
      run_vec(32'd1234, 32'd1234, 3'b110); // R4 equal operands
      run_vec('0, 32'd1, 3'b110);          // R4 borrow to all ones
      run_vec(MNEG, 32'd1, 3'b110);        // R4
   endtask

   task automatic t_slt;
      run_vec(32'd3, 32'd7, 3'b111);       // R7 less
      run_vec(32'd7, 32'd3, 3'b111);       // R7 greater
      run_vec(32'd9, 32'd9, 3'b111);       // R7 equal
      run_vec(ONES, '0, 3'b111);           // R7 -1 < 0
      apply(MNEG, 32'd1, 3'b111);          // R7 overflow ignored
      check_now("R7", '0);
      apply(32'h7FFF_FFFF, ONES, 3'b111);  // R7 overflow: 0x7fffffff-(-1)=MNEG
      check_now("R7", 32'd1);
   endtask

   task automatic t_reserved;
      apply(ONES, 32'h1234_5678, 3'b011);
      check_now("R8", '0);
      apply(MNEG, MNEG, 3'b011);
      check_now("R8", '0);
   endtask

   task automatic t_no_state;
      // R10: each vector differs from the last, so a stale value would show.
      run_vec(ONES, ONES, 3'b001);
      apply(32'h0000_0001, 32'h0000_0002, 3'b000);
      check_now("R10", '0);
      apply(32'h0000_0001, 32'h0000_0002, 3'b010);
      check_now("R10", 32'd3);
   endtask

   task automatic t_random;
      for (int i = 0; i < 150; i++) begin
         logic [W-1:0] x, v;
         x = $urandom;
         v = (i % 5 == 0) ? x : $urandom;
         for (int c = 0; c < 8; c++) run_vec(x, v, 3'(c));
      end
   endtask

   initial begin
      a = '0; b = '0; f = '0;
      repeat (2) @(posedge clk);
      t_start_state();
      t_logic_ops();
      t_arith();
      t_slt();
      t_reserved();
      t_no_state();
      t_random();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule